// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host with a byte-wide bus reach a 1024-entry internal register space whose entries are up to 36 bits wide. The host sees only eight byte locations. Five of them stage one internal word a byte at a time. Two of them hold the internal address. One is reserved. Accessing the lowest data byte moves a whole word between the staging registers and the internal location.

To write a word, the host first sets the address. It then writes whichever upper staging bytes the word needs, and writes the low byte last; that last write sends the whole staged word to the internal space. To read a word, the host sets the address and reads the low byte. That read fetches the internal word, returns its low byte, and keeps the upper bytes so the host can read them afterwards. Either access can optionally advance the internal address, which makes block transfers shorter.

The internal side returns read data combinationally while the read strobe is high. Host read data is valid in the cycle after the host read strobe. Host read and write strobes are not meant to be asserted together; if they are, the write is performed and the read is ignored.

Top module: `ireg_bridge`

## Requirements
- R1: Host offsets decode as follows: 0 to 4 are staging bytes S0 to S4, 5 is reserved, 6 is the address-low register and 7 is the mode register. A host read returns the selected register on `host_rdata` in the cycle after `host_re`.
- R2: `int_addr` is the mode register's bits 1:0 followed by the 8 bits of the address-low register.
- R3: S4 stores only its low 4 bits and reads back with bits 7:4 as zero. The mode register stores bits 7, 6, 1 and 0 and reads its bits 5:2 as zero.
- R4: Offset 5 reads as 0x00, and writing it changes no register and starts no internal access.
- R5: A host write to S0 stores the byte and, in the next cycle, raises `int_we` for exactly one cycle. During that cycle `int_wdata` is {S4[3:0], S3, S2, S1, S0}, where S0 is the newly written byte.
- R6: Host writes to S1 to S4 only stage data and raise no `int_we`. A later commit reuses staged bytes that have not been rewritten.
- R7: A host read of S0 raises `int_re` for exactly one cycle in the next cycle. In that cycle `host_rdata` equals `int_rdata[7:0]`, and S1 to S4 take `int_rdata[35:8]`.
- R8: Host reads of S1 to S4, the address-low register and the mode register start no internal access.
- R9: With mode bit 7 set, each commit advances the 10-bit internal address by one, wrapping from 0x3FF to 0x000. With bit 7 clear, the address does not change.
- R10: With mode bit 6 set, each S0 fetch advances the 10-bit address by one. With bit 6 clear, repeated fetches use the same address.
- R11: A synchronous active-high reset clears all registers to zero and holds both internal strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read byte, valid the cycle after host_re |
| int_addr | output | 10 | Internal address |
| int_wdata | output | 36 | Internal write word |
| int_we | output | 1 | Internal write pulse |
| int_re | output | 1 | Internal read pulse |
| int_rdata | input | 36 | Internal read word, valid while int_re is high |

## Verification
Full 36-bit commits are compared with a commit that rewrites only S0; the difference shows whether the staged upper bytes are kept. Fetches are made both with the read-increment bit clear and with it set, starting below the wrap point. This separates a held address from an advancing one, and a correct upper-byte latch from a stale one. Write-increment runs start at 0x3FF, so the wrap to 0x000 and the carry into the mode register's address bits can both be seen. Writes and reads to the reserved offset, to S4 and to the mode register show that the unused bits are dropped.

// File: rtl/ireg_bridge.sv
module ireg_bridge (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_wdata,
  input  logic        host_we,
  input  logic        host_re,
  output logic [7:0]  host_rdata,
  output logic [9:0]  int_addr,
  output logic [35:0] int_wdata,
  output logic        int_we,
  output logic        int_re,
  input  logic [35:0] int_rdata
);

  logic [7:0] s0, s1, s2, s3, lo;
  logic [3:0] s4;
  logic [1:0] hi;
  logic       winc, rinc, wr_pend, rd_pend;
  logic [7:0] rd_q;
  logic       rd;

  assign rd         = host_re && !host_we;
  assign int_addr   = {hi, lo};
  assign int_wdata  = {s4, s3, s2, s1, s0};
  assign int_we     = wr_pend;
  assign int_re     = rd_pend;
  assign host_rdata = rd_pend ? int_rdata[7:0] : rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      {s0, s1, s2, s3, s4, lo, hi} <= '0;
      {winc, rinc, wr_pend, rd_pend} <= '0;
      rd_q <= '0;
    end else begin
      wr_pend <= host_we && host_addr == 3'd0;
      rd_pend <= rd && host_addr == 3'd0;
      if ((wr_pend && winc) || (rd_pend && rinc))
        {hi, lo} <= int_addr + 10'd1;
      if (rd_pend)
        {s4, s3, s2, s1, s0} <= int_rdata;
      if (host_we) begin
        case (host_addr)
          3'd0: s0 <= host_wdata;
          3'd1: s1 <= host_wdata;
          3'd2: s2 <= host_wdata;
          3'd3: s3 <= host_wdata;
          3'd4: s4 <= host_wdata[3:0];
          3'd6: lo <= host_wdata;
          3'd7: {winc, rinc, hi} <= {host_wdata[7:6], host_wdata[1:0]};
          default: ;
        endcase
      end
      if (rd) begin
        case (host_addr)
          3'd1: rd_q <= s1;
          3'd2: rd_q <= s2;
          3'd3: rd_q <= s3;
          3'd4: rd_q <= {4'h0, s4};
          3'd6: rd_q <= lo;
          3'd7: rd_q <= {winc, rinc, 4'h0, hi};
          default: rd_q <= 8'h00;
        endcase
      end
    end
  end

  p_commit_r5: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == 3'd0) |=> (int_we && int_wdata[7:0] == $past(host_wdata)));

  p_stage_only_r6: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr != 3'd0) |=> !int_we);

  p_fetch_r7: assert property (@(posedge clk) disable iff (rst)
    (rd && host_addr == 3'd0) |=> int_re);

  p_no_access_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && host_addr != 3'd0) |=> (!int_re && !int_we));

  p_winc_r9: assert property (@(posedge clk) disable iff (rst)
    (int_we && winc && !host_we) |=> int_addr == $past(int_addr) + 10'd1);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!host_we && !int_re && !(int_we && winc)) |=> $stable(int_addr));

  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!int_we && !int_re && int_addr == 10'd0));

endmodule

// File: tb/test_ireg_bridge.sv
module test_ireg_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [7:0]  host_rdata;
  logic [9:0]  int_addr;
  logic [35:0] int_wdata, int_rdata;
  logic        int_we, int_re;

  logic [35:0] mem [1024];
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic        cap_we, cap_re;
  logic [9:0]  cap_addr;
  logic [35:0] cap_wdata;

  always #5 clk = ~clk;

  ireg_bridge i_ireg_bridge (.*);

  assign int_rdata = mem[int_addr];
  always @(posedge clk) if (int_we) mem[int_addr] <= int_wdata;

  function automatic logic [35:0] pat(int i);
    logic [9:0] a = i[9:0];
    return {a[3:0] ^ 4'h5, a[7:0], 8'hC3 ^ a[9:2], ~a[7:0], a[7:0] + 8'h11};
  endfunction

  task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk); host_we = 1'b0;
    cap_we = int_we; cap_re = int_re; cap_addr = int_addr; cap_wdata = int_wdata;
  endtask

  task automatic hrd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_re = 1'b1;
    @(negedge clk); host_re = 1'b0;
    d = host_rdata; cap_we = int_we; cap_re = int_re; cap_addr = int_addr;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(!int_we && !int_re && int_addr == 0, "R11", {int_we, int_re, int_addr}, 0);
    hrd(3'd6, d); check(d == 0, "R11 lo", d, 0);
    hrd(3'd7, d); check(d == 0, "R11 mode", d, 0);
    hrd(3'd1, d); check(d == 0, "R11 s1", d, 0);
  endtask

  task automatic t_window();
    logic [7:0] d;
    hwr(3'd6, 8'h5A); hwr(3'd7, 8'hFF);
    hrd(3'd6, d); check(d == 8'h5A, "R1 lo readback", d, 8'h5A);
    hrd(3'd7, d); check(d == 8'hC3, "R3 mode reserved", d, 8'hC3);
    check(int_addr == 10'h35A, "R2 address", int_addr, 10'h35A);
    hwr(3'd4, 8'hFF); check(!cap_we, "R6 s4 stage", cap_we, 0);
    hrd(3'd4, d); check(d == 8'h0F, "R3 s4 nibble", d, 8'h0F);
    hwr(3'd1, 8'h12); check(!cap_we, "R6 s1 stage", cap_we, 0);
    hrd(3'd1, d); check(d == 8'h12 && !cap_re, "R8 s1 read", {cap_re, d}, 8'h12);
    hwr(3'd5, 8'hFF); check(!cap_we && !cap_re, "R4 reserved write", {cap_we, cap_re}, 0);
    hrd(3'd5, d); check(d == 0, "R4 reserved read", d, 0);
    hrd(3'd6, d); check(d == 8'h5A, "R4 lo unchanged", d, 8'h5A);
    hrd(3'd1, d); check(d == 8'h12, "R4 s1 unchanged", d, 8'h12);
  endtask

  task automatic t_commit();
    logic [7:0] d;
    hwr(3'd7, 8'h02); hwr(3'd6, 8'h34);
    hwr(3'd4, 8'h09); hwr(3'd3, 8'hCB); hwr(3'd2, 8'hEF); hwr(3'd1, 8'hEF);
    hwr(3'd0, 8'hFF);
    check(cap_we && cap_addr == 10'h234 && cap_wdata == 36'h9CBEFEFFF, "R5 commit",
          cap_wdata, 36'h9CBEFEFFF);
    @(negedge clk); check(!int_we, "R5 single pulse", int_we, 0);
    check(int_addr == 10'h234, "R9 no winc hold", int_addr, 10'h234);
    hwr(3'd0, 8'h01);
    check(cap_wdata == 36'h9CBEFEF01, "R6 staged reuse", cap_wdata, 36'h9CBEFEF01);
    hrd(3'd0, d);
    check(cap_re && d == 8'h01, "R7 fetch low", {cap_re, d}, {1'b1, 8'h01});
    @(negedge clk); check(!int_re, "R7 single pulse", int_re, 0);
    hrd(3'd3, d); check(d == 8'hCB && !cap_re, "R7 s3", d, 8'hCB);
    hrd(3'd4, d); check(d == 8'h09, "R7 s4", d, 8'h09);
  endtask

  task automatic t_winc();
    logic [7:0] d;
    hwr(3'd7, 8'h83); hwr(3'd6, 8'hFF);
    hwr(3'd0, 8'hA1); check(cap_addr == 10'h3FF, "R9 first addr", cap_addr, 10'h3FF);
    hwr(3'd0, 8'hA2); check(cap_addr == 10'h000, "R9 wrap", cap_addr, 10'h000);
    hrd(3'd6, d); check(d == 8'h01, "R9 lo after", d, 8'h01);
    hrd(3'd7, d); check(d == 8'h80, "R9 mode carry", d, 8'h80);
    check(mem[10'h3FF][7:0] == 8'hA1 && mem[0][7:0] == 8'hA2, "R9 stored",
          {mem[10'h3FF][7:0], mem[0][7:0]}, 16'hA1A2);
  endtask

  task automatic t_rinc();
    logic [7:0] d;
    logic [35:0] e;
    hwr(3'd7, 8'h00); hwr(3'd6, 8'h10);
    hrd(3'd0, d); hrd(3'd0, d);
    check(cap_addr == 10'h010, "R10 no rinc hold", cap_addr, 10'h010);
    hwr(3'd7, 8'h40);
    for (int k = 0; k < 3; k++) begin
      e = pat(16 + k);
      hrd(3'd0, d);
      check(cap_addr == 10'(16 + k) && d == e[7:0], "R10 rinc fetch", {cap_addr, d}, {10'(16 + k), e[7:0]});
      hrd(3'd2, d); check(d == e[23:16], "R7 s2 latched", d, e[23:16]);
      hrd(3'd4, d); check(d == {4'h0, e[35:32]}, "R7 s4 latched", d, e[35:32]);
    end
    hrd(3'd6, d); check(d == 8'h13, "R10 lo after", d, 8'h13);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_window();
    t_commit();
    t_winc();
    t_rinc();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule